// File: doc/BRIEF.md
# Program Counter with Hardware Return Stack

This block keeps the 10-bit instruction address of a small 8-bit controller and a five-entry return stack beside it. Each clock is one instruction cycle. A decoded operation code, the 8-bit accumulator or register-write value, and a 10-bit target field come in. The block presents the fetch address of the instruction now executing, together with a stall flag.

Any operation that redirects the program counter is followed by one refill cycle. During that cycle the stall flag is high, the operation input is ignored and the address holds at the new target. The stack is circular: it has no overflow or underflow detection and raises no error.

The control is a two-state machine. `SEQ_ISSUE` accepts an operation. If the operation redirects, the transition *redirect* leads to `SEQ_REFILL`. Otherwise the transition *advance* stays in `SEQ_ISSUE`. `SEQ_REFILL` always takes the transition *resume* back to `SEQ_ISSUE`.

Top module: `pc_stack_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, the fetch address is 000h and stall is 0.
- R2: The operation STEP (code 0) in `SEQ_ISSUE` raises the address by one on the next clock, wrapping 3FFh to 000h, and never raises stall.
- R3: ADDREL (code 1) loads (address + 1 + zero-extended byte) modulo 1024, so the carry reaches bits 9:8.
- R4: LDLO (code 2) and WRLO (code 3) replace bits 7:0 with the byte input and keep bits 9:8.
- R5: JUMP (code 4) loads all 10 bits from the target field.
- R6: CALL (code 5) loads the target field and pushes address + 1 (wrapped). RETURN (code 6) loads the top stack entry and pops it.
- R7: IRQ (code 7) loads 008h and pushes the current address, which a later RETURN restores.
- R8: Every code other than STEP accepted in `SEQ_ISSUE` makes stall 1 for exactly the next cycle. During that cycle the operation input has no effect and the address holds.
- R9: The stack returns values in last-in first-out order for up to five entries. A sixth push overwrites the oldest entry.
- R10: A pop with no valid entry returns the slot at the wrapped pointer. Right after reset this slot holds 000h, and after six pushes and five pops it holds the sixth pushed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Decoded operation code (0 STEP … 7 IRQ) |
| byte_i | input | 8 | Accumulator or register-write value |
| addr_i | input | 10 | Jump or call target field |
| pc_o | output | 10 | Fetch address of the executing instruction |
| stall_o | output | 1 | Refill-cycle flag following a redirect |

## Verification
Stepping across 3FFh separates a correct wrap from a counter that grows into an eleventh bit. The relative add is tried both with and without a carry into bit 8, which tells a full-width add apart from a byte-only add. Low-byte loads start from an address whose bits 9:8 are not zero, so a load that clears those bits shows up. The call chain pushes six frames and pops six. This shows last-in first-out order, overwrite of the oldest entry, and the wrapped read, and it separates a circular pointer from a saturating one.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        OP_STEP   = 3'd0,
        OP_ADDREL = 3'd1,
        OP_LDLO   = 3'd2,
        OP_WRLO   = 3'd3,
        OP_JUMP   = 3'd4,
        OP_CALL   = 3'd5,
        OP_RETURN = 3'd6,
        OP_IRQ    = 3'd7
    } pcs_op_e;

    typedef enum logic {
        SEQ_ISSUE  = 1'b0,
        SEQ_REFILL = 1'b1
    } pcs_seq_e;

endpackage

// File: rtl/pcs_seq.sv
module pcs_seq
    import pcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic redirect_i,
    output logic accept_o,
    output logic stall_o
);

    pcs_seq_e state_q;
    pcs_seq_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_ISSUE:  state_d = redirect_i ? SEQ_REFILL : SEQ_ISSUE;
            SEQ_REFILL: state_d = SEQ_ISSUE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_ISSUE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept_o = 1'b0;
        stall_o  = 1'b0;
        unique case (state_q)
            SEQ_ISSUE:  accept_o = 1'b1;
            SEQ_REFILL: stall_o  = 1'b1;
        endcase
    end

endmodule

// File: rtl/pcs_next.sv
module pcs_next
    import pcs_pkg::*;
#(
    parameter int PC_W    = 10,
    parameter int DATA_W  = 8,
    parameter logic [PC_W-1:0] IRQ_VEC = 10'h008
) (
    input  logic              accept_i,
    input  logic [2:0]        op_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic [PC_W-1:0]   addr_i,
    input  logic [PC_W-1:0]   top_i,
    output logic [PC_W-1:0]   pc_d_o,
    output logic              redirect_o,
    output logic              push_o,
    output logic [PC_W-1:0]   push_data_o,
    output logic              pop_o
);

    localparam int HI_W = PC_W - DATA_W;

    pcs_op_e           op;
    logic [PC_W-1:0]   pc_inc;
    logic [PC_W-1:0]   pc_rel;
    logic [PC_W-1:0]   pc_low;

    assign op     = pcs_op_e'(op_i);
    assign pc_inc = PC_W'(pc_i + PC_W'(1));
    assign pc_rel = PC_W'(pc_inc + PC_W'(byte_i));
    assign pc_low = {pc_i[PC_W-1 -: HI_W], byte_i};

    always_comb begin
        pc_d_o      = pc_i;
        redirect_o  = 1'b0;
        push_o      = 1'b0;
        push_data_o = pc_inc;
        pop_o       = 1'b0;
        if (accept_i) begin
            unique case (op)
                OP_STEP: pc_d_o = pc_inc;
                OP_ADDREL: begin
                    pc_d_o     = pc_rel;
                    redirect_o = 1'b1;
                end
                OP_LDLO, OP_WRLO: begin
                    pc_d_o     = pc_low;
                    redirect_o = 1'b1;
                end
                OP_JUMP: begin
                    pc_d_o     = addr_i;
                    redirect_o = 1'b1;
                end
                OP_CALL: begin
                    pc_d_o      = addr_i;
                    redirect_o  = 1'b1;
                    push_o      = 1'b1;
                    push_data_o = pc_inc;
                end
                OP_RETURN: begin
                    pc_d_o     = top_i;
                    redirect_o = 1'b1;
                    pop_o      = 1'b1;
                end
                OP_IRQ: begin
                    pc_d_o      = IRQ_VEC;
                    redirect_o  = 1'b1;
                    push_o      = 1'b1;
                    push_data_o = pc_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
    parameter int W     = 10,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] top_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;
    logic [W-1:0]     slot_q [DEPTH];

    assign ptr_up = (ptr_q == LAST) ? '0 : PTR_W'(ptr_q + PTR_W'(1));
    assign ptr_dn = (ptr_q == '0) ? LAST : PTR_W'(ptr_q - PTR_W'(1));
    assign top_o  = slot_q[ptr_dn];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr_q <= '0;
        else if (push_i) ptr_q <= ptr_up;
        else if (pop_i)  ptr_q <= ptr_dn;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (push_i && (ptr_q == PTR_W'(g)))
                slot_q[g] <= push_data_i;
        end
    end

endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit #(
    parameter int PC_W    = 10,
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 5,
    parameter logic [PC_W-1:0] IRQ_VEC = 10'h008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic [PC_W-1:0]   addr_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              stall_o
);

    logic              accept;
    logic              redirect;
    logic              push;
    logic              pop;
    logic [PC_W-1:0]   push_data;
    logic [PC_W-1:0]   top;
    logic [PC_W-1:0]   pc_q;
    logic [PC_W-1:0]   pc_d;

    pcs_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .redirect_i (redirect),
        .accept_o   (accept),
        .stall_o    (stall_o)
    );

    pcs_next #(.PC_W(PC_W), .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC)) u_next (
        .accept_i    (accept),
        .op_i        (op_i),
        .pc_i        (pc_q),
        .byte_i      (byte_i),
        .addr_i      (addr_i),
        .top_i       (top),
        .pc_d_o      (pc_d),
        .redirect_o  (redirect),
        .push_o      (push),
        .push_data_o (push_data),
        .pop_o       (pop)
    );

    pcs_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (push_data),
        .pop_i       (pop),
        .top_o       (top)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
    parameter int PC_W    = 10,
    parameter int DATA_W  = 8,
    parameter logic [PC_W-1:0] IRQ_VEC = 10'h008
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic [DATA_W-1:0] byte_i,
    input logic [PC_W-1:0]   addr_i,
    input logic [PC_W-1:0]   pc_o,
    input logic              stall_o
);

    localparam int HI_W = PC_W - DATA_W;

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_state: assert (pc_o == '0 && !stall_o);
        end
    end

    a_r2_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && op_i == 3'd0) |=> (pc_o == PC_W'($past(pc_o) + PC_W'(1)) && !stall_o));

    a_r4_keep_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && (op_i == 3'd2 || op_i == 3'd3)) |=>
        (pc_o[PC_W-1 -: HI_W] == $past(pc_o[PC_W-1 -: HI_W]) && pc_o[DATA_W-1:0] == $past(byte_i)));

    a_r5_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && op_i == 3'd4) |=> (pc_o == $past(addr_i)));

    a_r6_call_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && op_i == 3'd5) |=> (pc_o == $past(addr_i)));

    a_r7_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && op_i == 3'd7) |=> (pc_o == IRQ_VEC));

    a_r8_redirect_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && op_i != 3'd0) |=> stall_o);

    a_r8_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (!stall_o && $stable(pc_o)));

endmodule

bind pc_stack_unit pcs_checker #(.PC_W(PC_W), .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC)) u_pcs_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .byte_i  (byte_i),
    .addr_i  (addr_i),
    .pc_o    (pc_o),
    .stall_o (stall_o)
);

// File: tb/test_pc_stack_unit.sv
module test_pc_stack_unit;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] STEP = 3'd0, ADDREL = 3'd1, LDLO = 3'd2, WRLO = 3'd3,
                           JUMP = 3'd4, CALL = 3'd5, RETURN = 3'd6, IRQ = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = STEP;
    logic [7:0] byte_i = '0;
    logic [9:0] addr_i = '0;
    logic [9:0] pc_o;
    logic       stall_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pc_stack_unit i_pc_stack_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op_i),
        .byte_i  (byte_i),
        .addr_i  (addr_i),
        .pc_o    (pc_o),
        .stall_o (stall_o)
    );

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op_i  = STEP;
        repeat (2) @(posedge clk);
        #1;
        check("R1 pc in reset", pc_o, 10'h000);
        check("R1 stall in reset", {9'd0, stall_o}, 10'd0);
        rst_n = 1'b1;
        #1;
        check("R1 pc after release", pc_o, 10'h000);
    endtask

    // Issue one operation; for a redirect, let the refill cycle pass with STEP.
    task automatic issue(input logic [2:0] o, input logic [7:0] b, input logic [9:0] a);
        op_i = o; byte_i = b; addr_i = a;
        @(posedge clk);
        #1;
        op_i = STEP;
        if (o != STEP) begin
            check("R8 stall after redirect", {9'd0, stall_o}, 10'd1);
            @(posedge clk);
            #1;
            check("R8 stall cleared", {9'd0, stall_o}, 10'd0);
        end else begin
            check("R2 no stall on step", {9'd0, stall_o}, 10'd0);
        end
    endtask

    task automatic t_step();
        do_reset();
        issue(STEP, 8'h00, 10'h000); check("R2 step 1", pc_o, 10'h001);
        issue(STEP, 8'h00, 10'h000); check("R2 step 2", pc_o, 10'h002);
        issue(JUMP, 8'h00, 10'h3FE); check("R5 jump 3FE", pc_o, 10'h3FE);
        issue(STEP, 8'h00, 10'h000); check("R2 step 3FF", pc_o, 10'h3FF);
        issue(STEP, 8'h00, 10'h000); check("R2 wrap to 000", pc_o, 10'h000);
    endtask

    task automatic t_add();
        issue(JUMP, 8'h00, 10'h0FA);
        issue(ADDREL, 8'h10, 10'h000); check("R3 carry into bit8", pc_o, 10'h10B);
        issue(JUMP, 8'h00, 10'h123);
        issue(ADDREL, 8'h05, 10'h000); check("R3 no carry", pc_o, 10'h129);
        issue(JUMP, 8'h00, 10'h3F0);
        issue(ADDREL, 8'hFF, 10'h000); check("R3 wrap past 3FF", pc_o, 10'h0F0);
    endtask

    task automatic t_low();
        issue(JUMP, 8'h00, 10'h2C5);
        issue(LDLO, 8'h33, 10'h000); check("R4 byte load keeps 9:8", pc_o, 10'h233);
        issue(JUMP, 8'h00, 10'h1A0);
        issue(WRLO, 8'h7E, 10'h3FF); check("R4 reg write keeps 9:8", pc_o, 10'h17E);
    endtask

    task automatic t_bubble();
        op_i = JUMP; addr_i = 10'h155;
        @(posedge clk); #1;
        check("R8 stall raised", {9'd0, stall_o}, 10'd1);
        check("R5 jump target", pc_o, 10'h155);
        op_i = JUMP; addr_i = 10'h3AA;
        @(posedge clk); #1;
        op_i = STEP;
        check("R8 op ignored in refill", pc_o, 10'h155);
        check("R8 single stall cycle", {9'd0, stall_o}, 10'd0);
    endtask

    task automatic t_call_irq();
        issue(JUMP, 8'h00, 10'h100);
        issue(CALL, 8'h00, 10'h200); check("R6 call target", pc_o, 10'h200);
        issue(STEP, 8'h00, 10'h000);
        issue(RETURN, 8'h00, 10'h000); check("R6 return to pc+1", pc_o, 10'h101);
        issue(JUMP, 8'h00, 10'h050);
        issue(IRQ, 8'h00, 10'h000); check("R7 irq vector", pc_o, 10'h008);
        issue(RETURN, 8'h00, 10'h000); check("R7 irq return", pc_o, 10'h050);
    endtask

    task automatic t_deep();
        do_reset();
        issue(RETURN, 8'h00, 10'h000); check("R10 empty pop after reset", pc_o, 10'h000);
        do_reset();
        for (int k = 1; k <= 6; k++) begin
            issue(CALL, 8'h00, 10'(k * 10'h040));
        end
        issue(RETURN, 8'h00, 10'h000); check("R9 pop 1", pc_o, 10'h141);
        issue(RETURN, 8'h00, 10'h000); check("R9 pop 2", pc_o, 10'h101);
        issue(RETURN, 8'h00, 10'h000); check("R9 pop 3", pc_o, 10'h0C1);
        issue(RETURN, 8'h00, 10'h000); check("R9 pop 4", pc_o, 10'h081);
        issue(RETURN, 8'h00, 10'h000); check("R9 pop 5 oldest overwritten", pc_o, 10'h041);
        issue(RETURN, 8'h00, 10'h000); check("R10 wrapped pop", pc_o, 10'h141);
    endtask

    initial begin
        t_step();
        t_add();
        t_low();
        t_bubble();
        t_call_irq();
        t_deep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule